// File: doc/BRIEF.md
# CompactFlash Cold-Boot Sequencer

This block holds a processor in reset after power-up while it prepares a CompactFlash card to hand over the first instructions. It talks to the card's ATA task-file registers over a small register bus. It programs a one-sector read of logical block zero and polls the card's status register between steps. When the card signals that the data is waiting, the block releases the processor's reset. From then on, processor reads in the lowest 512 bytes of the address space become reads of the card's 16-bit data register. The processor therefore fetches its first code straight out of the card's boot sector.

A jumper-driven select input picks the boot flow when the block leaves reset. In card mode the sequence above runs. In serial mode the block stays off the card bus, does not map the low window, and releases the processor at once, so another loader can take over. An error reported by the card, or a card that stays busy for too long in any poll phase, leaves the processor held in reset and raises an error output.

Top module: `cfboot_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cpu_rst` is high, `boot_err` is low, and neither `cf_rd` nor `cf_wr` pulses.
- R2: With `boot_sel` low when reset ends, `cpu_rst` falls within two cycles. No card access ever occurs, and processor reads do not hit the window.
- R3: With `boot_sel` high, the block makes exactly six single-cycle writes, in this order: register 2 ← 0x01 (sector count), register 3 ← 0x00, register 4 ← 0x00, register 5 ← 0x00 (block address 0), register 6 ← 0xE0 (LBA addressing, master device), register 7 ← 0x20 (read-sectors command).
- R4: Every write is preceded by a status read (register 7) in which bit 7 (busy) was clear. No write follows a read that showed busy.
- R5: `cpu_rst` falls in card mode only after a status read that follows the command and shows bit 7 clear and bit 3 (data request) set.
- R6: A status read with bit 0 (error) set moves the block to a terminal error state. `boot_err` rises, `cpu_rst` stays high, and no further card access occurs. The error bit wins even when the same read also shows ready.
- R7: Each poll phase allows at most TIMEOUT status reads. If ready appears on read number TIMEOUT, the sequence goes on, so ready wins over expiry in that cycle. If it does not appear by then, the error state of R6 is entered.
- R8: After release in card mode, a processor read with address below 0x200 drives `cf_rd` in the same cycle with `cf_addr` = 0. It raises `win_hit` and returns `cf_rdata` on `cpu_rdata`.
- R9: A processor read at address 0x200 or above produces no `cf_rd`, keeps `win_hit` low, and returns zero.
- R10: After release the block makes no further card access on its own, and `cpu_rst` stays low until `rst`.
- R11: A later `rst` restarts the whole flow from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up / button reset |
| boot_sel | input | 1 | 1 = card boot, 0 = serial boot (bypass) |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_rd | input | 1 | Processor read request |
| cpu_rdata | output | 16 | Card data returned for window reads, else zero |
| win_hit | output | 1 | Current processor read falls in the boot window |
| cpu_rst | output | 1 | Active-high reset to the processor |
| boot_err | output | 1 | Card error or timeout during the boot sequence |
| cf_addr | output | 3 | Task-file register index |
| cf_wdata | output | 16 | Write data to the card (low byte used) |
| cf_rdata | input | 16 | Read data from the card |
| cf_rd | output | 1 | Card read strobe |
| cf_wr | output | 1 | Card write strobe |

## Verification
Two decisions can land in the same status-read cycle. The poll counter can reach its last allowed read just as the card turns ready. The card can also raise its error bit on the very read that shows busy clear. The bench's card stub stays busy for exactly TIMEOUT-1 reads per phase to provoke the first case, and busy for TIMEOUT reads for the contrasting case. Success is judged by the processor's release and the six logged writes; failure is judged by `boot_err` with exactly TIMEOUT status reads and no write. The second case uses a stub that reports ready and error together on the first read, and the bench expects the error state with no write made.

// File: rtl/cfboot_pkg.sv
package cfboot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_WRITE,
        ST_WAIT,
        ST_RUN,
        ST_BYPASS,
        ST_ERR
    } boot_state_e;

    localparam int TF_AW     = 3;
    localparam int NUM_STEPS = 6;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    localparam logic [TF_AW-1:0] TF_DATA    = 3'd0;
    localparam logic [TF_AW-1:0] TF_SECCNT  = 3'd2;
    localparam logic [TF_AW-1:0] TF_LBA_LO  = 3'd3;
    localparam logic [TF_AW-1:0] TF_LBA_MID = 3'd4;
    localparam logic [TF_AW-1:0] TF_LBA_HI  = 3'd5;
    localparam logic [TF_AW-1:0] TF_DEVSEL  = 3'd6;
    localparam logic [TF_AW-1:0] TF_STATCMD = 3'd7;

    localparam int SB_BUSY = 7;
    localparam int SB_DRQ  = 3;
    localparam int SB_ERR  = 0;

    localparam logic [7:0] CMD_RD_SECTORS = 8'h20;
    localparam logic [7:0] DEV_LBA_MASTER = 8'hE0;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [TF_AW-1:0] addr;
        logic [7:0]       wdata;
    } tf_req_t;

    localparam tf_req_t TF_REQ_NONE = '{rd: 1'b0, wr: 1'b0, addr: '0, wdata: '0};

    // Register index and value for each step of the command program.
    function automatic tf_req_t step_write(input logic [STEP_W-1:0] step);
        tf_req_t r;
        r    = TF_REQ_NONE;
        r.wr = 1'b1;
        case (step)
            3'd0:    begin r.addr = TF_SECCNT;  r.wdata = 8'h01;          end
            3'd1:    begin r.addr = TF_LBA_LO;  r.wdata = 8'h00;          end
            3'd2:    begin r.addr = TF_LBA_MID; r.wdata = 8'h00;          end
            3'd3:    begin r.addr = TF_LBA_HI;  r.wdata = 8'h00;          end
            3'd4:    begin r.addr = TF_DEVSEL;  r.wdata = DEV_LBA_MASTER; end
            default: begin r.addr = TF_STATCMD; r.wdata = CMD_RD_SECTORS; end
        endcase
        return r;
    endfunction

    function automatic logic stat_ready(input logic [7:0] s, input logic need_drq);
        return !s[SB_BUSY] && (!need_drq || s[SB_DRQ]);
    endfunction

endpackage

// File: rtl/cfboot_timer.sv
module cfboot_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic last
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && !last) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CNT_W'(LIMIT - 1));

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(LIMIT - 1));

endmodule

// File: rtl/cfboot_seq.sv
module cfboot_seq
    import cfboot_pkg::*;
#(
    parameter int TIMEOUT = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       boot_sel,
    input  logic [7:0] status,
    output tf_req_t    req,
    output logic       run,
    output logic       cpu_rst,
    output logic       boot_err
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    boot_state_e       state, state_nx;
    logic [STEP_W-1:0] step, step_nx;
    logic              polling, need_drq, rdy, err_seen, tmo_last;

    assign polling  = (state == ST_POLL) || (state == ST_WAIT);
    assign need_drq = (state == ST_WAIT);
    assign rdy      = stat_ready(status, need_drq);
    assign err_seen = status[SB_ERR];

    cfboot_timer #(.LIMIT(TIMEOUT)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (!polling),
        .en   (polling),
        .last (tmo_last)
    );

    always_comb begin
        state_nx = state;
        step_nx  = step;
        req      = TF_REQ_NONE;
        unique case (state)
            ST_IDLE: begin
                step_nx  = '0;
                state_nx = boot_sel ? ST_POLL : ST_BYPASS;
            end
            ST_POLL, ST_WAIT: begin
                req.rd   = 1'b1;
                req.addr = TF_STATCMD;
                // error first, then ready, then expiry
                if (err_seen)      state_nx = ST_ERR;
                else if (rdy)      state_nx = (state == ST_POLL) ? ST_WRITE : ST_RUN;
                else if (tmo_last) state_nx = ST_ERR;
            end
            ST_WRITE: begin
                req = step_write(step);
                if (step == LAST_STEP) begin
                    state_nx = ST_WAIT;
                end else begin
                    step_nx  = step + 1'b1;
                    state_nx = ST_POLL;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            state <= state_nx;
            step  <= step_nx;
        end
    end

    assign run      = (state == ST_RUN);
    assign cpu_rst  = !((state == ST_RUN) || (state == ST_BYPASS));
    assign boot_err = (state == ST_ERR);

    // R4
    wr_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
        req.wr |-> $past(req.rd && !status[SB_BUSY]));

    // R5
    hold_until_drq_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !(status[SB_DRQ] && !status[SB_BUSY])) |=> cpu_rst);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        boot_err |=> (boot_err && cpu_rst && !req.rd && !req.wr));

    // R10
    run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        run |=> (run && !cpu_rst && !req.rd && !req.wr));

    // R1
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!req.rd && !req.wr && cpu_rst));

endmodule

// File: rtl/cfboot_window.sv
module cfboot_window
    import cfboot_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 9,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  tf_req_t           seq_req,
    input  logic [DATA_W-1:0] cf_rdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              win_hit,
    output logic [TF_AW-1:0]  cf_addr,
    output logic [DATA_W-1:0] cf_wdata,
    output logic              cf_rd,
    output logic              cf_wr
);
    logic in_win;

    assign in_win  = (cpu_addr[ADDR_W-1:WIN_BITS] == '0);
    assign win_hit = run && cpu_rd && in_win;

    always_comb begin
        if (run) begin
            cf_rd    = win_hit;
            cf_wr    = 1'b0;
            cf_addr  = TF_DATA;
            cf_wdata = '0;
        end else begin
            cf_rd    = seq_req.rd;
            cf_wr    = seq_req.wr;
            cf_addr  = seq_req.addr;
            cf_wdata = DATA_W'(seq_req.wdata);
        end
    end

    assign cpu_rdata = win_hit ? cf_rdata : '0;

    // R9
    outside_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !(cpu_rd && in_win)) |-> (!cf_rd && !win_hit && cpu_rdata == '0));

    // R8
    data_reg_only_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cf_rd) |-> (cf_addr == TF_DATA && !cf_wr));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cf_rd && cf_wr));

endmodule

// File: rtl/cfboot_ctrl.sv
module cfboot_ctrl
    import cfboot_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 9,
    parameter int TIMEOUT  = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_sel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    output logic [15:0]       cpu_rdata,
    output logic              win_hit,
    output logic              cpu_rst,
    output logic              boot_err,
    output logic [2:0]        cf_addr,
    output logic [15:0]       cf_wdata,
    input  logic [15:0]       cf_rdata,
    output logic              cf_rd,
    output logic              cf_wr
);
    localparam int DATA_W = 16;

    tf_req_t seq_req;
    logic    run;

    cfboot_seq #(.TIMEOUT(TIMEOUT)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .boot_sel (boot_sel),
        .status   (cf_rdata[7:0]),
        .req      (seq_req),
        .run      (run),
        .cpu_rst  (cpu_rst),
        .boot_err (boot_err)
    );

    cfboot_window #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .DATA_W   (DATA_W)
    ) win_i (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .seq_req   (seq_req),
        .cf_rdata  (cf_rdata),
        .cpu_rdata (cpu_rdata),
        .win_hit   (win_hit),
        .cf_addr   (cf_addr),
        .cf_wdata  (cf_wdata),
        .cf_rd     (cf_rd),
        .cf_wr     (cf_wr)
    );

    // R2
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rst && !win_hit && !cpu_rd) |-> (!cf_rd && !cf_wr));

endmodule

// File: tb/cfboot_ctrl_tb_top.sv
module cfboot_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_sel = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic [15:0] cpu_rdata, cf_wdata, cf_rdata;
    logic        win_hit, cpu_rst, boot_err, cf_rd, cf_wr;
    logic [2:0]  cf_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfboot_ctrl #(.ADDR_W(16), .WIN_BITS(9), .TIMEOUT(TMO)) dut_i (
        .clk(clk), .rst(rst), .boot_sel(boot_sel),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .win_hit(win_hit), .cpu_rst(cpu_rst), .boot_err(boot_err),
        .cf_addr(cf_addr), .cf_wdata(cf_wdata), .cf_rdata(cf_rdata),
        .cf_rd(cf_rd), .cf_wr(cf_wr)
    );

    // card stub configuration
    int busy_n = 0;
    logic err_en = 1'b0;
    int err_phase = 0;

    // card stub state
    int rdcnt, wr_n, didx, poll_viol, acc_n, rel_viol;
    logic cmd_done, rdy_seen, drq_seen, prev_crst;
    logic [2:0] wr_a [16];
    logic [7:0] wr_d [16];
    logic bsy, drq, errb;
    logic [7:0] stat;

    assign bsy  = (rdcnt < busy_n);
    assign drq  = !bsy && cmd_done;
    assign errb = err_en && (wr_n == err_phase);
    assign stat = {bsy, 1'b1, 2'b00, drq, 2'b00, errb};
    assign cf_rdata = (cf_addr == 3'd7) ? {8'h00, stat} :
                      (cf_addr == 3'd0) ? (16'hB000 + 16'(didx)) : 16'h0000;

    always @(posedge clk) begin
        if (rst) begin
            rdcnt <= 0; wr_n <= 0; didx <= 0; poll_viol <= 0; acc_n <= 0;
            cmd_done <= 1'b0; rdy_seen <= 1'b0; drq_seen <= 1'b0;
        end else begin
            if (cf_rd || cf_wr) acc_n <= acc_n + 1;
            if (cf_rd && cf_addr == 3'd7) begin
                rdcnt <= rdcnt + 1;
                if (!stat[7]) rdy_seen <= 1'b1;
                if (!stat[7] && stat[3]) drq_seen <= 1'b1;
            end
            if (cf_rd && cf_addr == 3'd0) didx <= didx + 1;
            if (cf_wr) begin
                if (!rdy_seen) poll_viol <= poll_viol + 1;
                rdy_seen <= 1'b0;
                rdcnt <= 0;
                if (wr_n < 16) begin
                    wr_a[wr_n] <= cf_addr;
                    wr_d[wr_n] <= cf_wdata[7:0];
                end
                wr_n <= wr_n + 1;
                if (cf_addr == 3'd7) cmd_done <= 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            rel_viol  <= 0;
            prev_crst <= 1'b1;
        end else begin
            if (prev_crst && !cpu_rst && boot_sel && !drq_seen) rel_viol <= rel_viol + 1;
            prev_crst <= cpu_rst;
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start(input logic sel, input int busy, input logic een, input int eph);
        @(negedge clk);
        rst = 1'b1; cpu_rd = 1'b0; cpu_addr = '0;
        boot_sel = sel; busy_n = busy; err_en = een; err_phase = eph;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 1000; i++) begin
            if (!cpu_rst || boot_err) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_program(input string tag);
        logic [2:0] ea [6];
        logic [7:0] ed [6];
        ea = '{3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
        ed = '{8'h01, 8'h00, 8'h00, 8'h00, 8'hE0, 8'h20};
        chk({tag, " write count"}, wr_n, 6);
        for (int i = 0; i < 6; i++) begin
            chk($sformatf("%s write %0d addr", tag, i), int'(wr_a[i]), int'(ea[i]));
            chk($sformatf("%s write %0d data", tag, i), int'(wr_d[i]), int'(ed[i]));
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst = 1'b1; boot_sel = 1'b1; busy_n = 0; err_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 cpu_rst in reset", int'(cpu_rst), 1);
        chk("R1 boot_err in reset", int'(boot_err), 0);
        chk("R1 strobes in reset", int'(cf_rd | cf_wr), 0);
        rst = 1'b0;
        #1;
        chk("R1 cpu_rst first cycle", int'(cpu_rst), 1);
        chk("R1 strobes first cycle", int'(cf_rd | cf_wr), 0);
    endtask

    task automatic test_boot_ok();
        start(1'b1, 3, 1'b0, 0);
        settle();
        chk("R5 released", int'(cpu_rst), 0);
        chk("R5 no early release", rel_viol, 0);
        chk("R6 no error", int'(boot_err), 0);
        check_program("R3");
        chk("R4 poll before writes", poll_viol, 0);
    endtask

    task automatic test_window();
        int a0;
        // continues from a released card boot
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 16'h0000; #1;
        chk("R8 cf_rd at 0x000", int'(cf_rd), 1);
        chk("R8 cf_addr data reg", int'(cf_addr), 0);
        chk("R8 win_hit", int'(win_hit), 1);
        chk("R8 data word 0", int'(cpu_rdata), 16'hB000);
        @(negedge clk);
        cpu_addr = 16'h01FE; #1;
        chk("R8 data word 1 at 0x1FE", int'(cpu_rdata), 16'hB001);
        @(negedge clk);
        cpu_addr = 16'h0200; #1;
        chk("R9 no cf_rd at 0x200", int'(cf_rd), 0);
        chk("R9 no hit at 0x200", int'(win_hit), 0);
        chk("R9 zero data at 0x200", int'(cpu_rdata), 0);
        @(negedge clk);
        cpu_addr = 16'h8000; #1;
        chk("R9 no cf_rd at 0x8000", int'(cf_rd), 0);
        @(negedge clk);
        cpu_addr = 16'h0000; #1;
        chk("R8 data word 2", int'(cpu_rdata), 16'hB002);
        @(negedge clk);
        cpu_rd = 1'b0;
        a0 = acc_n;
        repeat (20) @(negedge clk);
        chk("R10 no card access after release", acc_n - a0, 0);
        chk("R10 still released", int'(cpu_rst), 0);
    endtask

    task automatic test_timeout_edge();
        start(1'b1, TMO - 1, 1'b0, 0);
        settle();
        chk("R7 ready on last read proceeds", int'(cpu_rst), 0);
        chk("R7 no error on last read", int'(boot_err), 0);
        chk("R7 writes at edge", wr_n, 6);
        start(1'b1, TMO, 1'b0, 0);
        settle();
        chk("R7 expiry error", int'(boot_err), 1);
        chk("R7 expiry holds reset", int'(cpu_rst), 1);
        chk("R7 reads before expiry", acc_n, TMO);
        chk("R7 no write on expiry", wr_n, 0);
    endtask

    task automatic test_err();
        int a0;
        start(1'b1, 2, 1'b1, 2);
        settle();
        chk("R6 error raised", int'(boot_err), 1);
        chk("R6 reset held", int'(cpu_rst), 1);
        chk("R6 writes before error", wr_n, 2);
        a0 = acc_n;
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 16'h0000; #1;
        chk("R6 window unmapped in error", int'(win_hit), 0);
        repeat (30) @(negedge clk);
        cpu_rd = 1'b0;
        chk("R6 no access after error", acc_n - a0, 0);
        chk("R6 still held", int'(cpu_rst), 1);
        // error and ready in the same read
        start(1'b1, 0, 1'b1, 0);
        settle();
        chk("R6 error beats ready", int'(boot_err), 1);
        chk("R6 no write on error", wr_n, 0);
    endtask

    task automatic test_bypass();
        start(1'b0, 0, 1'b0, 0);
        repeat (2) @(negedge clk);
        chk("R2 released in bypass", int'(cpu_rst), 0);
        chk("R2 no error in bypass", int'(boot_err), 0);
        cpu_rd = 1'b1; cpu_addr = 16'h0010; #1;
        chk("R2 no cf_rd in bypass", int'(cf_rd), 0);
        chk("R2 no hit in bypass", int'(win_hit), 0);
        repeat (10) @(negedge clk);
        cpu_rd = 1'b0;
        chk("R2 no card access", acc_n, 0);
    endtask

    task automatic test_rerun();
        start(1'b1, 1, 1'b0, 0);
        settle();
        chk("R11 rerun released", int'(cpu_rst), 0);
        check_program("R11");
        chk("R11 no early release", rel_viol, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        test_reset();
        test_boot_ok();
        test_window();
        test_timeout_edge();
        test_err();
        test_bypass();
        test_rerun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule